// File: doc/BRIEF.md
# Byte ALU with Status Flags

This block is the byte-wide execute stage of a small 16-bit controller core. It decodes a 16-bit instruction word and combines an 8-bit source operand with an 8-bit destination operand. It returns the byte to write back, a write enable for that byte, an illegal-instruction indication, and the status word that the operation would produce. Operand fetch, register file, memory and stack handling live outside the block.

The status word is held in a register inside the block. It is updated when an instruction is presented with `op_valid_i` and that instruction changes flags. The core can also overwrite it directly through `sr_wr_i`, for example when software writes the status register. Only the carry, zero, negative and overflow bits are ever touched by an operation. All other status bits keep the value last loaded.

Top module: `byte_alu_flags`

## Requirements
- R1: Decode. When bits 15:12 are 4 or more, the instruction is two-operand and those bits select the operation: 4 MOV, 5 ADD, 6 ADDC, 7 SUBC, 8 SUB, 9 CMP, 10 DADD, 11 BIT, 12 BIC, 13 BIS, 14 XOR, 15 AND. When bits 15:10 equal 000100, the instruction is single-operand and bits 9:7 select the operation: 0 RRC, 2 RRA, 4 PUSH. All other words are illegal.
- R2: In the status word, C is bit 0, Z is bit 1, N is bit 2 and V is bit 8. Every flag update keeps all other bits unchanged.
- R3: The adder computes dst + B + cin with a 9-bit sum. The (B, cin) pair is (src, 0) for ADD, (src, C) for ADDC, (~src, 1) for SUB and (~src, C) for SUBC. C is the carry out of bit 7, Z is set when the result is zero, and N is result bit 7.
- R4: For ADD, ADDC, SUB, SUBC and CMP, V is set when dst and B have equal bit 7 and result bit 7 differs from them.
- R5: CMP updates the flags like SUB but keeps `wr_en_o` low.
- R6: For BIT, AND and XOR, N is result bit 7, Z is set when the result is zero, and C equals not Z. XOR sets V when both operands have bit 7 set. AND and BIT clear V. AND and XOR write the result, and BIT does not.
- R7: MOV writes src, BIC writes dst AND NOT src, and BIS writes dst OR src. None of the three changes the status word.
- R8: RRC and RRA operate on dst and write the result. RRC gives {C, dst[7:1]} and RRA gives {dst[7], dst[7:1]}. Both set C to dst bit 0, clear V, and take Z and N from the result.
- R9: DADD, PUSH and every illegal word raise `illegal_o`, keep `wr_en_o` low and leave the status word unchanged.
- R10: The status register resets to 0. It loads `sr_wdata_i` when `sr_wr_i` is high, and `sr_wr_i` takes priority over an operation. Otherwise it takes `flags_next_o` at the clock edge when `op_valid_i` is high.
- R11: With both `op_valid_i` and `sr_wr_i` low, the status register holds its value whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Instruction is executed this cycle |
| instr_i | input | 16 | Instruction word |
| src_i | input | 8 | Source operand byte |
| dst_i | input | 8 | Destination operand byte (sole operand for shifts) |
| sr_wr_i | input | 1 | Direct status register write |
| sr_wdata_i | input | 16 | Status value for direct write |
| result_o | output | 8 | Result byte |
| wr_en_o | output | 1 | Result byte should be written back |
| illegal_o | output | 1 | Instruction not handled by this block |
| flags_next_o | output | 16 | Status word the instruction would produce |
| status_o | output | 16 | Registered status word |

## Verification
The checker assumes that `op_valid_i`, `sr_wr_i` and `instr_i` are known, not X, on every clock edge after reset. Its status-stability properties also assume that a direct status write never coincides with an operation it judges, so each of those properties is qualified by `sr_wr_i` being low. The stimulus drives all inputs on the falling edge and never raises `op_valid_i` and `sr_wr_i` in the same cycle. It loads random status words, upper bits included, so that the preservation of the bits outside the flags is actually exercised.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;
  localparam int unsigned INSTR_W = 16;
  localparam int unsigned SR_W    = 16;
  localparam int unsigned FLAG_C  = 0;
  localparam int unsigned FLAG_Z  = 1;
  localparam int unsigned FLAG_N  = 2;
  localparam int unsigned FLAG_V  = 8;

  typedef enum logic [3:0] {
    OP_MOV, OP_ADD, OP_ADDC, OP_SUBC, OP_SUB, OP_CMP, OP_BIT, OP_BIC,
    OP_BIS, OP_XOR, OP_AND, OP_RRC, OP_RRA, OP_BAD
  } alu_op_e;
endpackage

// File: rtl/byte_alu_decode.sv
module byte_alu_decode
  import byte_alu_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output alu_op_e            op_o
);
  always_comb begin
    op_o = OP_BAD;
    if (instr_i[15:12] >= 4'd4) begin
      unique case (instr_i[15:12])
        4'd4:    op_o = OP_MOV;
        4'd5:    op_o = OP_ADD;
        4'd6:    op_o = OP_ADDC;
        4'd7:    op_o = OP_SUBC;
        4'd8:    op_o = OP_SUB;
        4'd9:    op_o = OP_CMP;
        4'd11:   op_o = OP_BIT;
        4'd12:   op_o = OP_BIC;
        4'd13:   op_o = OP_BIS;
        4'd14:   op_o = OP_XOR;
        4'd15:   op_o = OP_AND;
        default: op_o = OP_BAD; // decimal add not handled
      endcase
    end else if (instr_i[15:10] == 6'b000100) begin
      unique case (instr_i[9:7])
        3'd0:    op_o = OP_RRC;
        3'd2:    op_o = OP_RRA;
        default: op_o = OP_BAD; // push and undefined codes
      endcase
    end
  end
endmodule

// File: rtl/byte_alu_arith.sv
module byte_alu_arith
  import byte_alu_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  alu_op_e       op_i,
  input  logic [DW-1:0] src_i,
  input  logic [DW-1:0] dst_i,
  input  logic          c_i,
  output logic [DW-1:0] res_o,
  output logic          c_o,
  output logic          v_o
);
  localparam int unsigned MSB = DW - 1;

  logic          is_sub;
  logic          cin;
  logic [DW-1:0] addend;
  logic [DW:0]   sum;

  always_comb begin
    is_sub = (op_i == OP_SUB) || (op_i == OP_SUBC) || (op_i == OP_CMP);
    addend = is_sub ? ~src_i : src_i;
    unique case (op_i)
      OP_ADD:             cin = 1'b0;
      OP_SUB, OP_CMP:     cin = 1'b1;
      default:            cin = c_i;
    endcase
    sum   = {1'b0, dst_i} + {1'b0, addend} + {{DW{1'b0}}, cin};
    res_o = sum[DW-1:0];
    c_o   = sum[DW];
    v_o   = (dst_i[MSB] == addend[MSB]) && (sum[MSB] != dst_i[MSB]);
  end
endmodule

// File: rtl/byte_alu_logic.sv
module byte_alu_logic
  import byte_alu_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  alu_op_e       op_i,
  input  logic [DW-1:0] src_i,
  input  logic [DW-1:0] dst_i,
  input  logic          c_i,
  output logic [DW-1:0] res_o,
  output logic          c_o,
  output logic          v_o
);
  localparam int unsigned MSB = DW - 1;

  always_comb begin
    res_o = src_i;
    c_o   = 1'b0;
    v_o   = 1'b0;
    unique case (op_i)
      OP_BIT, OP_AND: begin
        res_o = dst_i & src_i;
        c_o   = |res_o;
      end
      OP_XOR: begin
        res_o = dst_i ^ src_i;
        c_o   = |res_o;
        v_o   = dst_i[MSB] & src_i[MSB];
      end
      OP_BIC: res_o = dst_i & ~src_i;
      OP_BIS: res_o = dst_i | src_i;
      OP_RRC: begin
        res_o = {c_i, dst_i[MSB:1]};
        c_o   = dst_i[0];
      end
      OP_RRA: begin
        res_o = {dst_i[MSB], dst_i[MSB:1]};
        c_o   = dst_i[0];
      end
      default: res_o = src_i;
    endcase
  end
endmodule

// File: rtl/byte_alu_flags.sv
module byte_alu_flags
  import byte_alu_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               op_valid_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [DW-1:0]      src_i,
  input  logic [DW-1:0]      dst_i,
  input  logic               sr_wr_i,
  input  logic [SR_W-1:0]    sr_wdata_i,
  output logic [DW-1:0]      result_o,
  output logic               wr_en_o,
  output logic               illegal_o,
  output logic [SR_W-1:0]    flags_next_o,
  output logic [SR_W-1:0]    status_o
);
  localparam int unsigned MSB = DW - 1;

  alu_op_e         op;
  logic [SR_W-1:0] status_q;
  logic [DW-1:0]   arith_res, logic_res;
  logic            arith_c, arith_v, logic_c, logic_v;
  logic            is_arith, upd_flags;
  logic            new_c, new_v;

  byte_alu_decode u_dec (.instr_i(instr_i), .op_o(op));

  byte_alu_arith #(.DW(DW)) u_arith (
    .op_i(op), .src_i(src_i), .dst_i(dst_i), .c_i(status_q[FLAG_C]),
    .res_o(arith_res), .c_o(arith_c), .v_o(arith_v)
  );

  byte_alu_logic #(.DW(DW)) u_logic (
    .op_i(op), .src_i(src_i), .dst_i(dst_i), .c_i(status_q[FLAG_C]),
    .res_o(logic_res), .c_o(logic_c), .v_o(logic_v)
  );

  always_comb begin
    is_arith = op inside {OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_CMP};
    upd_flags = is_arith || (op inside {OP_BIT, OP_AND, OP_XOR, OP_RRC, OP_RRA});
    result_o  = is_arith ? arith_res : logic_res;
    new_c     = is_arith ? arith_c : logic_c;
    new_v     = is_arith ? arith_v : logic_v;
    wr_en_o   = !(op inside {OP_CMP, OP_BIT, OP_BAD});
    illegal_o = (op == OP_BAD);

    flags_next_o = status_q;
    if (upd_flags) begin
      flags_next_o[FLAG_C] = new_c;
      flags_next_o[FLAG_Z] = (result_o == '0);
      flags_next_o[FLAG_N] = result_o[MSB];
      flags_next_o[FLAG_V] = new_v;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         status_q <= '0;
    else if (sr_wr_i)    status_q <= sr_wdata_i;
    else if (op_valid_i) status_q <= flags_next_o;
  end

  assign status_o = status_q;
endmodule

// File: rtl/byte_alu_flags_chk.sv
module byte_alu_flags_chk
  import byte_alu_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               op_valid_i,
  input logic [INSTR_W-1:0] instr_i,
  input logic [DW-1:0]      dst_i,
  input logic               sr_wr_i,
  input logic [DW-1:0]      result_o,
  input logic               wr_en_o,
  input logic               illegal_o,
  input logic [SR_W-1:0]    flags_next_o,
  input logic [SR_W-1:0]    status_o
);
  assert_illegal_nowrite_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !wr_en_o);

  assert_cmp_nowrite_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_i[15:12] == 4'd9) |-> (!wr_en_o && !illegal_o));

  assert_move_keeps_flags_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && !sr_wr_i && (instr_i[15:12] inside {4'd4, 4'd12, 4'd13}))
      |=> (status_o == $past(status_o)));

  assert_illegal_keeps_flags_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && !sr_wr_i && illegal_o) |=> (status_o == $past(status_o)));

  assert_upper_bits_kept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && !sr_wr_i) |=> ((status_o[15:9] == $past(status_o[15:9])) &&
                                  (status_o[7:3]  == $past(status_o[7:3]))));

  assert_logic_carry_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_i[15:12] inside {4'd11, 4'd14, 4'd15})
      |-> (flags_next_o[FLAG_C] == !flags_next_o[FLAG_Z]));

  assert_shift_carry_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((instr_i[15:10] == 6'b000100) && (instr_i[9:7] inside {3'd0, 3'd2}))
      |-> (flags_next_o[FLAG_C] == dst_i[0] && result_o[DW-2:0] == dst_i[DW-1:1]));

  assert_idle_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!op_valid_i && !sr_wr_i) |=> $stable(status_o));
endmodule

bind byte_alu_flags byte_alu_flags_chk #(.DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .op_valid_i(op_valid_i), .instr_i(instr_i),
  .dst_i(dst_i), .sr_wr_i(sr_wr_i), .result_o(result_o), .wr_en_o(wr_en_o),
  .illegal_o(illegal_o), .flags_next_o(flags_next_o), .status_o(status_o)
);

// File: tb/sim_byte_alu_flags.sv
module sim_byte_alu_flags;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [15:0] instr = '0;
  logic [7:0]  src = '0, dst = '0;
  logic        sr_wr = 1'b0;
  logic [15:0] sr_wdata = '0;
  logic [7:0]  result;
  logic        wr_en, illegal;
  logic [15:0] flags_next, status;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_sr = '0;

  always #4 clk = ~clk;

  byte_alu_flags u0 (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_valid), .instr_i(instr),
    .src_i(src), .dst_i(dst), .sr_wr_i(sr_wr), .sr_wdata_i(sr_wdata),
    .result_o(result), .wr_en_o(wr_en), .illegal_o(illegal),
    .flags_next_o(flags_next), .status_o(status)
  );

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic void model(input logic [15:0] ins, input logic [7:0] s, input logic [7:0] d,
                                input logic [15:0] sr, output logic [7:0] r, output logic w,
                                output logic il, output logic [15:0] nsr);
    logic [8:0] sum;
    logic [7:0] b;
    logic       upd, c, v;
    r = s; w = 1'b0; il = 1'b0; upd = 1'b0; c = 1'b0; v = 1'b0;
    if (ins[15:12] >= 4) begin
      case (ins[15:12])
        4, 12, 13: begin
          w = 1'b1;
          r = (ins[15:12] == 4) ? s : (ins[15:12] == 12) ? (d & ~s) : (d | s);
        end
        5, 6, 7, 8, 9: begin
          b   = (ins[15:12] >= 7) ? ~s : s;
          sum = {1'b0, d} + {1'b0, b} +
                ((ins[15:12] == 5) ? 9'd0 : (ins[15:12] >= 8) ? 9'd1 : {8'd0, sr[0]});
          r = sum[7:0]; c = sum[8];
          v = (d[7] == b[7]) && (r[7] != d[7]);
          upd = 1'b1; w = (ins[15:12] != 9);
        end
        11, 14, 15: begin
          r = (ins[15:12] == 14) ? (d ^ s) : (d & s);
          c = (r != 0);
          v = (ins[15:12] == 14) && d[7] && s[7];
          upd = 1'b1; w = (ins[15:12] != 11);
        end
        default: il = 1'b1;
      endcase
    end else if (ins[15:10] == 6'b000100 && (ins[9:7] == 0 || ins[9:7] == 2)) begin
      r = {(ins[9:7] == 0) ? sr[0] : d[7], d[7:1]};
      c = d[0]; upd = 1'b1; w = 1'b1;
    end else il = 1'b1;
    nsr = sr;
    if (upd) begin
      nsr[0] = c; nsr[1] = (r == 0); nsr[2] = r[7]; nsr[8] = v;
    end
  endfunction

  task automatic run_op(input logic [15:0] ins, input logic [7:0] s, input logic [7:0] d,
                        input string req);
    logic [7:0]  er;
    logic        ew, eil;
    logic [15:0] ensr;
    @(negedge clk);
    instr = ins; src = s; dst = d; op_valid = 1'b1;
    #1;
    model(ins, s, d, exp_sr, er, ew, eil, ensr);
    chk({req, " wr_en"}, {15'd0, wr_en}, {15'd0, ew});
    chk({req, " illegal"}, {15'd0, illegal}, {15'd0, eil});
    chk({req, " flags_next"}, flags_next, ensr);
    if (ew) chk({req, " result"}, {8'd0, result}, {8'd0, er});
    @(posedge clk); #1;
    op_valid = 1'b0;
    exp_sr = ensr;
    chk({req, " status R10"}, status, exp_sr);
  endtask

  task automatic load_sr(input logic [15:0] v);
    @(negedge clk);
    sr_wr = 1'b1; sr_wdata = v;
    @(posedge clk); #1;
    sr_wr = 1'b0;
    exp_sr = v;
    chk("R10 load", status, exp_sr);
  endtask

  function automatic logic [15:0] two(input int op);
    return {op[3:0], 12'(($urandom & 32'hFFF))};
  endfunction

  function automatic logic [15:0] one(input int code);
    return {6'b000100, code[2:0], 7'(($urandom & 32'h7F))};
  endfunction

  initial begin
    void'($urandom(32'd1234));
    #20;
    chk("R10 reset", status, 16'h0000);
    rst_n = 1'b1;
    #10;

    // directed corner cases
    run_op(two(5), 8'h01, 8'h7F, "R4 add overflow");
    run_op(two(5), 8'h01, 8'hFF, "R3 add carry zero");
    load_sr(16'hA5F1);
    run_op(two(6), 8'h10, 8'h20, "R3 addc carry in");
    run_op(two(8), 8'h05, 8'h05, "R3 sub equal");
    run_op(two(8), 8'h01, 8'h00, "R3 sub borrow");
    run_op(two(8), 8'h01, 8'h80, "R4 sub overflow");
    load_sr(16'h7E00);
    run_op(two(7), 8'h01, 8'h05, "R3 subc no carry");
    run_op(two(9), 8'h33, 8'h33, "R5 cmp");
    run_op(two(14), 8'h80, 8'h80, "R6 xor both negative");
    run_op(two(11), 8'hF0, 8'h0F, "R6 bit zero");
    run_op(two(15), 8'hC3, 8'h81, "R6 and");
    load_sr(16'hFEF8);
    run_op(two(4), 8'h5A, 8'h00, "R7 mov");
    run_op(two(12), 8'h0F, 8'hFF, "R7 bic");
    run_op(two(13), 8'h0F, 8'hF0, "R7 bis");
    load_sr(16'h0001);
    run_op(one(0), 8'h00, 8'h01, "R8 rrc");
    run_op(one(2), 8'h00, 8'h81, "R8 rra");
    load_sr(16'h1237);
    run_op(two(10), 8'h12, 8'h34, "R9 dadd");
    run_op(one(4), 8'h12, 8'h34, "R9 push");
    run_op(one(1), 8'h12, 8'h34, "R9 undefined single");
    run_op(16'h2000, 8'h12, 8'h34, "R1 jump word illegal");
    run_op(16'h1400, 8'h12, 8'h34, "R1 other format illegal");

    // idle cycle: inputs change, no op_valid
    @(negedge clk);
    instr = two(5); src = 8'hFF; dst = 8'hFF;
    @(posedge clk); #1;
    chk("R11 idle hold", status, exp_sr);

    // random mix
    for (int i = 0; i < 600; i++) begin
      int k;
      k = $urandom_range(0, 9);
      if (k == 0) load_sr(16'($urandom));
      else if (k < 3) run_op(one($urandom_range(0, 7)), 8'($urandom), 8'($urandom), "R8 R9 random single");
      else if (k < 9) run_op(two($urandom_range(4, 15)), 8'($urandom), 8'($urandom), "R2 R3 R6 random two");
      else run_op(16'($urandom), 8'($urandom), 8'($urandom), "R1 random word");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule